// File: doc/BRIEF.md
# Dual-Mode SHA-2 Message Schedule Generator

This block produces the per-round schedule word for the SHA-2 compression rounds. One 64-bit datapath serves two configurations. In wide mode it runs a single 64-bit lane, as used by the 384/512-bit digests. In split mode the same registers and adders run two independent 32-bit lanes, as used by the 224/256-bit digests. The upper half carries one lane and the lower half carries the other. The mode is captured when a block starts and is held until that block has ended.

A block begins with a one-cycle `start` pulse that carries the first message word. The fifteen message words that follow arrive on the next fifteen cycles, one per cycle. For those first sixteen rounds the block forwards each word unchanged. It then expands the schedule by itself from a sixteen-entry history: 48 further rounds in split mode, 64 in wide mode. The recurrence adds the small sigma-one of the word two rounds back, the word seven back, the small sigma-zero of the word fifteen back and the word sixteen back. Every result is registered and appears one cycle after the round's inputs are taken.

The controller has three states:
- `S_IDLE`: waiting for a block.
- `S_LOAD`: taking message words.
- `S_EXPAND`: computing words from the history.

The transitions are:
- `S_IDLE` goes to `S_LOAD` on `start`.
- `S_LOAD` goes to `S_EXPAND` once round 15 is taken.
- `S_EXPAND` goes back to `S_IDLE` once the last round of the mode is produced: round 63 in split mode, round 79 in wide mode.

Top module: `sha2_dual_sched`

## Requirements
- R1: After reset `w_valid`, `busy`, `w_is_msg`, `w_round` and `w_out` are all zero.
- R2: A `start` pulse in idle produces, on the next cycle, `w_valid`=1, `w_round`=0 and `w_out` equal to the `msg_in` presented with `start`.
- R3: For rounds 1 to 15, `w_out` equals the `msg_in` presented on the cycle before that round's output. Round t's word is presented t cycles after `start`.
- R4: In wide mode (`mode_split`=0 at start), rounds 16 to 79 follow the recurrence modulo 2^64. Here sigma0(x) = ror1^ror8^shr7 and sigma1(x) = ror19^ror61^shr6, all on 64 bits.
- R5: In split mode (`mode_split`=1 at start), bits [63:32] and bits [31:0] each follow the recurrence on their own 32-bit values, modulo 2^32, with no carry between the halves. Here sigma0(x) = ror7^ror18^shr3 and sigma1(x) = ror17^ror19^shr10.
- R6: `w_valid` stays high for exactly 64 consecutive cycles in split mode and 80 in wide mode. `w_round` rises by one each cycle, and `w_valid` is low on the cycle after the last round.
- R7: `mode_split` is sampled only with `start`. Changing it during a block has no effect on that block's words.
- R8: `start` is ignored while `busy` is high. It neither disturbs the running block nor starts another one.
- R9: `w_is_msg` is 1 exactly for output rounds 0 to 15 and 0 for computed rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a block; carries message word 0 |
| mode_split | input | 1 | 1 = two 32-bit lanes, 0 = one 64-bit lane; sampled with `start` |
| msg_in | input | 64 | Message word for the current load round |
| w_out | output | 64 | Schedule word; in split mode the upper and lower halves are separate lanes |
| w_valid | output | 1 | `w_out` holds a schedule word |
| w_round | output | 7 | Round index of `w_out` |
| w_is_msg | output | 1 | `w_out` is a forwarded message word |
| busy | output | 1 | A block is in progress |

## Verification
Assertions are checked on every cycle:
- The split adder never lets a carry cross bit 31 in split mode, and it gives a full 64-bit sum in wide mode.
- A start in idle moves the controller to the second load round.
- The latched mode stays fixed while busy.
- A start while busy only advances the round.
- Expansion ends on the mode's last round.
- Forwarded words equal the previous input.
- The message flag tracks the round index.

Only the bench's scenarios can show that the sigma wiring and the window taps give the right numbers. It compares every word of whole blocks in both modes against an independent model, including all-ones messages that force carries. It also shows the block length, the ignored mid-block mode change and the ignored extra start.

// File: rtl/sha2s_pkg.sv
package sha2s_pkg;
    localparam int DW          = 64;
    localparam int HW          = DW / 2;
    localparam int WIN_DEPTH   = 16;
    localparam int RND_W       = 7;
    localparam int LOAD_ROUNDS = 16;
    localparam int ROUNDS_NAR  = 64;
    localparam int ROUNDS_WIDE = 80;
    // history taps: entry 0 holds W(t-1)
    localparam int TAP_M2      = 1;
    localparam int TAP_M7      = 6;
    localparam int TAP_M15     = 14;
    localparam int TAP_M16     = 15;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOAD,
        S_EXPAND
    } sched_state_e;

    function automatic logic [HW-1:0] rot32(input logic [HW-1:0] x, input int n);
        return (x >> n) | (x << (HW - n));
    endfunction

    function automatic logic [DW-1:0] rot64(input logic [DW-1:0] x, input int n);
        return (x >> n) | (x << (DW - n));
    endfunction

    function automatic logic [HW-1:0] lo_sig0_32(input logic [HW-1:0] x);
        return rot32(x, 7) ^ rot32(x, 18) ^ (x >> 3);
    endfunction

    function automatic logic [HW-1:0] lo_sig1_32(input logic [HW-1:0] x);
        return rot32(x, 17) ^ rot32(x, 19) ^ (x >> 10);
    endfunction

    function automatic logic [DW-1:0] lo_sig0_64(input logic [DW-1:0] x);
        return rot64(x, 1) ^ rot64(x, 8) ^ (x >> 7);
    endfunction

    function automatic logic [DW-1:0] lo_sig1_64(input logic [DW-1:0] x);
        return rot64(x, 19) ^ rot64(x, 61) ^ (x >> 6);
    endfunction
endpackage

// File: rtl/sha2s_split_add.sv
module sha2s_split_add #(
    parameter int DW = 64
) (
    input  logic          split,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] sum
);
    localparam int HW = DW / 2;

    logic [HW:0]   lo_sum;
    logic          cross_c;
    logic [HW-1:0] hi_sum;

    always_comb begin
        lo_sum  = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]};
        cross_c = lo_sum[HW] & ~split;
        hi_sum  = a[DW-1:HW] + b[DW-1:HW] + {{(HW-1){1'b0}}, cross_c};
        sum     = {hi_sum, lo_sum[HW-1:0]};
    end

    // R5: in split mode the upper half sums only its own operands
    always_comb begin
        if (split) begin
            a_r5_no_cross_carry: assert (sum[DW-1:HW] == a[DW-1:HW] + b[DW-1:HW]);
        end else begin
            a_r4_full_carry: assert (sum == a + b);
        end
    end
endmodule

// File: rtl/sha2s_sigma.sv
module sha2s_sigma
    import sha2s_pkg::*;
#(
    parameter bit SIG_ONE = 1'b0
) (
    input  logic          split,
    input  logic [DW-1:0] x,
    output logic [DW-1:0] y
);
    logic [HW-1:0] nar_hi;
    logic [HW-1:0] nar_lo;
    logic [DW-1:0] wide;

    generate
        if (SIG_ONE) begin : g_sig1
            assign nar_hi = lo_sig1_32(x[DW-1:HW]);
            assign nar_lo = lo_sig1_32(x[HW-1:0]);
            assign wide   = lo_sig1_64(x);
        end else begin : g_sig0
            assign nar_hi = lo_sig0_32(x[DW-1:HW]);
            assign nar_lo = lo_sig0_32(x[HW-1:0]);
            assign wide   = lo_sig0_64(x);
        end
    endgenerate

    assign y = split ? {nar_hi, nar_lo} : wide;
endmodule

// File: rtl/sha2s_window.sv
module sha2s_window
    import sha2s_pkg::*;
#(
    parameter int WD    = DW,
    parameter int DEPTH = WIN_DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic [WD-1:0] din,
    output logic [WD-1:0] tap_m2,
    output logic [WD-1:0] tap_m7,
    output logic [WD-1:0] tap_m15,
    output logic [WD-1:0] tap_m16
);
    logic [WD-1:0] ent [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else if (shift_en) begin
            ent[0] <= din;
            for (int i = 1; i < DEPTH; i++) ent[i] <= ent[i-1];
        end
    end

    assign tap_m2  = ent[TAP_M2];
    assign tap_m7  = ent[TAP_M7];
    assign tap_m15 = ent[TAP_M15];
    assign tap_m16 = ent[TAP_M16];
endmodule

// File: rtl/sha2s_ctrl.sv
module sha2s_ctrl
    import sha2s_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode_split,
    output logic             adv,
    output logic             take_msg,
    output logic [RND_W-1:0] cur_rnd,
    output logic             mode_q,
    output logic             busy
);
    sched_state_e     state_q, state_d;
    logic [RND_W-1:0] rnd_q, rnd_d;
    logic             mode_d;
    logic [RND_W-1:0] last_rnd;

    assign last_rnd = mode_q ? RND_W'(ROUNDS_NAR - 1) : RND_W'(ROUNDS_WIDE - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rnd_q   <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            rnd_q   <= rnd_d;
            mode_q  <= mode_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        rnd_d    = rnd_q;
        mode_d   = mode_q;
        adv      = 1'b0;
        take_msg = 1'b0;
        cur_rnd  = rnd_q;
        unique case (state_q)
            S_IDLE: begin
                cur_rnd = '0;
                if (start) begin
                    adv      = 1'b1;
                    take_msg = 1'b1;
                    mode_d   = mode_split;
                    rnd_d    = RND_W'(1);
                    state_d  = S_LOAD;
                end
            end
            S_LOAD: begin
                adv      = 1'b1;
                take_msg = 1'b1;
                rnd_d    = rnd_q + RND_W'(1);
                if (rnd_q == RND_W'(LOAD_ROUNDS - 1)) state_d = S_EXPAND;
            end
            S_EXPAND: begin
                adv = 1'b1;
                if (rnd_q == last_rnd) begin
                    rnd_d   = '0;
                    state_d = S_IDLE;
                end else begin
                    rnd_d = rnd_q + RND_W'(1);
                end
            end
            default: begin
                state_d = S_IDLE;
                rnd_d   = '0;
            end
        endcase
    end

    assign busy = (state_q != S_IDLE);

    a_r2_start_enters_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start) |=> (state_q == S_LOAD && rnd_q == RND_W'(1)));

    a_r7_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_q));

    a_r6_block_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXPAND && rnd_q == last_rnd) |=> (state_q == S_IDLE));

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ((rnd_q == $past(rnd_q) + RND_W'(1)) || (state_q == S_IDLE)));
endmodule

// File: rtl/sha2_dual_sched.sv
module sha2_dual_sched
    import sha2s_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode_split,
    input  logic [63:0]   msg_in,
    output logic [63:0]   w_out,
    output logic          w_valid,
    output logic [6:0]    w_round,
    output logic          w_is_msg,
    output logic          busy
);
    logic             adv, take_msg, mode_q;
    logic [RND_W-1:0] cur_rnd;
    logic [DW-1:0]    t_m2, t_m7, t_m15, t_m16;
    logic [DW-1:0]    sg0, sg1, part_a, part_b, expand_w, next_w;

    sha2s_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_split (mode_split),
        .adv        (adv),
        .take_msg   (take_msg),
        .cur_rnd    (cur_rnd),
        .mode_q     (mode_q),
        .busy       (busy)
    );

    sha2s_window u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (adv),
        .din      (next_w),
        .tap_m2   (t_m2),
        .tap_m7   (t_m7),
        .tap_m15  (t_m15),
        .tap_m16  (t_m16)
    );

    sha2s_sigma #(.SIG_ONE(1'b0)) u_sg0 (.split(mode_q), .x(t_m15), .y(sg0));
    sha2s_sigma #(.SIG_ONE(1'b1)) u_sg1 (.split(mode_q), .x(t_m2),  .y(sg1));

    sha2s_split_add #(.DW(DW)) u_add_a (.split(mode_q), .a(sg1),    .b(t_m7),   .sum(part_a));
    sha2s_split_add #(.DW(DW)) u_add_b (.split(mode_q), .a(sg0),    .b(t_m16),  .sum(part_b));
    sha2s_split_add #(.DW(DW)) u_add_c (.split(mode_q), .a(part_a), .b(part_b), .sum(expand_w));

    assign next_w = take_msg ? msg_in : expand_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_out    <= '0;
            w_valid  <= 1'b0;
            w_round  <= '0;
            w_is_msg <= 1'b0;
        end else begin
            w_valid <= adv;
            if (adv) begin
                w_out    <= next_w;
                w_round  <= cur_rnd;
                w_is_msg <= take_msg;
            end else begin
                w_is_msg <= 1'b0;
            end
        end
    end

    a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && take_msg) |=> (w_out == $past(msg_in)));

    a_r9_msg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> (w_is_msg == (w_round < 7'd16)));
endmodule

// File: tb/sha2_dual_sched_tb.sv
module sha2_dual_sched_tb;
    typedef struct packed {
        logic [6:0]  rnd;
        logic        is_msg;
        logic        split;
        logic [63:0] val;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode_split = 1'b0;
    logic [63:0] msg_in = '0;
    logic [63:0] w_out;
    logic        w_valid;
    logic [6:0]  w_round;
    logic        w_is_msg;
    logic        busy;

    int   vectors = 0;
    int   miscompares = 0;
    int   run_len = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    sha2_dual_sched u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_split(mode_split),
        .msg_in(msg_in), .w_out(w_out), .w_valid(w_valid), .w_round(w_round),
        .w_is_msg(w_is_msg), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // independent reference arithmetic
    function automatic logic [31:0] rr32(input logic [31:0] x, input int n);
        logic [63:0] d;
        d = {x, x} >> n;
        return d[31:0];
    endfunction
    function automatic logic [63:0] rr64(input logic [63:0] x, input int n);
        logic [127:0] d;
        d = {x, x} >> n;
        return d[63:0];
    endfunction
    function automatic logic [31:0] nar_next(input logic [31:0] m2, m7, m15, m16);
        logic [31:0] s0, s1;
        s1 = rr32(m2, 17) ^ rr32(m2, 19) ^ (m2 >> 10);
        s0 = rr32(m15, 7) ^ rr32(m15, 18) ^ (m15 >> 3);
        return s1 + m7 + s0 + m16;
    endfunction
    function automatic logic [63:0] wide_next(input logic [63:0] m2, m7, m15, m16);
        logic [63:0] s0, s1;
        s1 = rr64(m2, 19) ^ rr64(m2, 61) ^ (m2 >> 6);
        s0 = rr64(m15, 1) ^ rr64(m15, 8) ^ (m15 >> 7);
        return s1 + m7 + s0 + m16;
    endfunction

    // monitor: pops the scoreboard whenever a word is presented
    always @(negedge clk) begin
        if (rst_n && w_valid) begin
            run_len++;
            if (q.size() == 0) begin
                check(1'b0, "R8", "unexpected word", w_out, 64'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(w_out == e.val,
                      (e.rnd == 0) ? "R2" : (e.rnd < 16) ? "R3" : (e.split ? "R5" : "R4"),
                      $sformatf("word round %0d", e.rnd), w_out, e.val);
                check(w_round == e.rnd, "R6", "round index", {57'h0, w_round}, {57'h0, e.rnd});
                check(w_is_msg == e.is_msg, "R9", "message flag",
                      {63'h0, w_is_msg}, {63'h0, e.is_msg});
            end
        end
    end

    task automatic run_block(input bit split, input logic [63:0] m[16],
                             input bit flip_mode, input bit poke_start);
        logic [63:0] w[80];
        int n;
        n = split ? 64 : 80;
        for (int t = 0; t < n; t++) begin
            if (t < 16) begin
                w[t] = m[t];
            end else if (split) begin
                w[t] = {nar_next(w[t-2][63:32], w[t-7][63:32], w[t-15][63:32], w[t-16][63:32]),
                        nar_next(w[t-2][31:0],  w[t-7][31:0],  w[t-15][31:0],  w[t-16][31:0])};
            end else begin
                w[t] = wide_next(w[t-2], w[t-7], w[t-15], w[t-16]);
            end
            q.push_back('{rnd: 7'(t), is_msg: (t < 16), split: split, val: w[t]});
        end
        run_len = 0;
        @(negedge clk);
        start = 1'b1; mode_split = split; msg_in = m[0];
        for (int i = 1; i < 16; i++) begin
            @(negedge clk);
            start = 1'b0; msg_in = m[i];
            if (flip_mode) mode_split = ~split;
        end
        for (int k = 0; k < n + 2; k++) begin
            @(negedge clk);
            msg_in = ~msg_in;
            start = (poke_start && k == 20);
        end
        start = 1'b0;
        check(w_valid == 1'b0, "R6", "valid after last round", {63'h0, w_valid}, 64'h0);
        check(q.size() == 0, "R6", "words left unproduced", 64'(q.size()), 64'h0);
        check(run_len == n, "R6", "block length", 64'(run_len), 64'(n));
        check(busy == 1'b0, poke_start ? "R8" : "R6", "busy after block", {63'h0, busy}, 64'h0);
        mode_split = 1'b0;
    endtask

    initial begin
        fork
            begin
                logic [63:0] m[16];
                repeat (3) @(negedge clk);
                check(w_valid == 0 && busy == 0 && w_is_msg == 0, "R1", "reset flags",
                      {61'h0, w_valid, busy, w_is_msg}, 64'h0);
                check(w_out == 0 && w_round == 0, "R1", "reset word", w_out, 64'h0);
                rst_n = 1'b1;
                @(negedge clk);
                // wide block, varied pattern (R4)
                for (int i = 0; i < 16; i++) m[i] = 64'h0123456789abcdef * 64'(i + 3) ^ 64'(i);
                run_block(1'b0, m, 1'b0, 1'b0);
                // split block, unrelated halves (R5)
                for (int i = 0; i < 16; i++) m[i] = {32'h61626380 ^ 32'(i * 7), 32'h9e3779b9 * 32'(i + 1)};
                run_block(1'b1, m, 1'b0, 1'b0);
                // all-ones: carries at every position (R5 then R4)
                for (int i = 0; i < 16; i++) m[i] = '1;
                run_block(1'b1, m, 1'b0, 1'b0);
                run_block(1'b0, m, 1'b0, 1'b0);
                // mode toggled mid-block (R7)
                for (int i = 0; i < 16; i++) m[i] = {32'(i), 32'hffffffff - 32'(i)};
                run_block(1'b1, m, 1'b1, 1'b0);
                run_block(1'b0, m, 1'b1, 1'b0);
                // start while busy (R8)
                for (int i = 0; i < 16; i++) m[i] = 64'hdeadbeef00000000 | 64'(i * 3);
                run_block(1'b0, m, 1'b0, 1'b1);
                run_block(1'b1, m, 1'b0, 1'b1);
            end
            begin
                repeat (20000) @(posedge clk);
                miscompares++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule